// File: doc/BRIEF.md
# Row-Major to Fractal Tile Address Sequencer

This block is a DMA-style address engine. It copies a row-major matrix held in flat memory into an on-chip scratchpad, where the matrix is stored as fractal tiles. Each tile is sixteen rows deep and 32 bytes wide, so it holds 512 bytes. The inner tile width in elements is 32 divided by the element size. That gives 32 elements for 1-byte types, 16 for 2-byte types and 8 for 4-byte types.

Software supplies a descriptor and pulses `start`. The descriptor carries the source base, destination base, row stride in bytes, row count, column count, element size and an ordering mode. The block then presents one 32-byte beat per cycle, and each beat pairs a source read address with a destination write address. The beat data passes straight from `rdData` to `wrData`.

The destination is filled contiguously. The source address follows the chosen tile order:

- **Left-operand order** (`modeZn` = 0): tiles stack down the row dimension first, then step to the next 32-byte column block.
- **Right-operand order** (`modeZn` = 1): tiles run across the column blocks of a 16-row band first, so the reduction dimension is innermost, then step to the next band.

A descriptor that fails a check is refused with a one-cycle error pulse and moves no data.

Top module: `ndnz_tile_loader`

## Requirements
- R1: After reset, `beatValid`, `busy`, `done` and `errFlag` are all low.
- R2: If the low 5 bits of `srcBase`, `dstBase` or `rowStride` are not all zero, a start pulse in idle raises `errFlag` for exactly the cycle after the start edge, and no beat is issued.
- R3: If `elemSize` is anything other than 1, 2 or 4, the start is refused in the same way as R2.
- R4: The start is also refused as in R2 in either of these cases:
  - `rowCount` is zero or not a multiple of 16.
  - `colCount` is zero or not a multiple of 32/`elemSize`.
- R5: Beat n (counting from 0) carries the destination address `dstBase + 32*n`.
- R6: With `modeZn` = 0, beat n reads `srcBase + row*rowStride + cb*32`, where the row index runs fastest through 16 rows and then across row bands, and the column block `cb` changes slowest.
- R7: With `modeZn` = 1, the 16 rows of one tile come first, then the column block advances, and the 16-row band advances last.
- R8: A transfer has `(rowCount/16) * (colCount*elemSize/32)` column blocks times 16 rows of beats. Each beat covers 32/`elemSize` elements.
- R9: While `beatValid` is high and `beatReady` is low, `beatValid` stays high and both addresses hold their values.
- R10: `done` is high for exactly the one cycle after the edge that accepts the last beat. `busy` is low in that cycle.
- R11: A start pulse while `busy` is high is ignored: the running address sequence continues unchanged and no second transfer follows.
- R12: `wrData` equals `rdData` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; the descriptor is sampled on the same edge |
| modeZn | input | 1 | 0 = left-operand tile order, 1 = right-operand tile order |
| elemSize | input | 3 | Element size in bytes (1, 2 or 4) |
| srcBase | input | ADDR_W | Source base byte address |
| dstBase | input | ADDR_W | Destination base byte address |
| rowStride | input | ADDR_W | Source row pitch in bytes |
| rowCount | input | DIM_W | Number of matrix rows |
| colCount | input | DIM_W | Number of matrix columns in elements |
| beatValid | output | 1 | Address pair is valid |
| beatReady | input | 1 | Consumer accepts the current beat |
| srcAddr | output | ADDR_W | Source read address of the beat |
| dstAddr | output | ADDR_W | Destination write address of the beat |
| rdData | input | 256 | Beat data read from the source |
| wrData | output | 256 | Beat data forwarded to the destination |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | One-cycle descriptor rejection pulse |

## Verification
The bench runs three kinds of transfer, and each one separates a different fault:

- **Left-operand order, 2-byte elements, two row bands and two column blocks.** This shows whether bands are walked before column blocks.
- **Left-operand order, 1-byte elements, a single band.** This exercises the element-size-dependent column-block count.
- **Right-operand order, 4-byte elements.** This only passes if the row pointer rewinds to the start of the band when the column block advances.

`beatReady` is driven in three ways: always high, alternating, and low one cycle in three. These patterns expose lost or duplicated beats under back-pressure.

The remaining tests check refusals and ignored starts:

- Misaligned, wrongly sized and mis-shaped descriptors must each be refused without a beat.
- A second start issued during a transfer must leave the expected address stream intact.

// File: rtl/ndnz_pkg.sv
package ndnz_pkg;
  localparam int BEAT_BYTES = 32;
  localparam int FRAC_ROWS  = 16;
  localparam int ALIGN_BITS = $clog2(BEAT_BYTES);
  localparam int RIDX_W     = $clog2(FRAC_ROWS);

  // control -> datapath strobes
  typedef struct packed {
    logic load;  // latch descriptor, clear position
    logic adv;   // current beat accepted, step position
  } ctl_strobe_t;
endpackage

// File: rtl/ndnz_ctrl.sv
module ndnz_ctrl
  import ndnz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] rowStride,
  input  logic [DIM_W-1:0]  rowCount,
  input  logic [DIM_W-1:0]  colCount,
  input  logic [2:0]        elemSize,
  input  logic              beatReady,
  input  logic              lastBeat,
  output ctl_strobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic              errFlag
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  logic alignOk, sizeOk, rowOk, colOk, descOk, take;
  logic [DIM_W-1:0] colMask;

  always_comb begin
    alignOk = (srcBase[ALIGN_BITS-1:0] == '0) && (dstBase[ALIGN_BITS-1:0] == '0)
              && (rowStride[ALIGN_BITS-1:0] == '0);
    sizeOk  = (elemSize == 3'd1) || (elemSize == 3'd2) || (elemSize == 3'd4);
    case (elemSize)
      3'd1:    colMask = DIM_W'((1 << ALIGN_BITS) - 1);
      3'd2:    colMask = DIM_W'((1 << (ALIGN_BITS - 1)) - 1);
      default: colMask = DIM_W'((1 << (ALIGN_BITS - 2)) - 1);
    endcase
    rowOk  = (rowCount != '0) && (rowCount[RIDX_W-1:0] == '0);
    colOk  = (colCount != '0) && ((colCount & colMask) == '0);
    descOk = alignOk && sizeOk && rowOk && colOk;
    take   = start && (state == ST_IDLE);
    strobe.load = take && descOk;
    strobe.adv  = (state == ST_RUN) && beatReady;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done    <= strobe.adv && lastBeat;
      errFlag <= take && !descOk;
      if (strobe.load)                 state <= ST_RUN;
      else if (strobe.adv && lastBeat) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/ndnz_addr.sv
module ndnz_addr
  import ndnz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic              modeZn,
  input  logic [2:0]        elemSize,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] rowStride,
  input  logic [DIM_W-1:0]  rowCount,
  input  logic [DIM_W-1:0]  colCount,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              lastBeat
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] rowPtr, colOff, dstPtr, strideQ, srcBaseQ, strideX15;
  logic [RIDX_W-1:0] rIdx;
  logic [DIM_W-1:0]  rbIdx, cbIdx, rbLastQ, cbLastQ, cbCount;
  logic              znQ, lastR, lastRb, lastCb;

  always_comb begin
    case (elemSize)
      3'd1:    cbCount = colCount >> ALIGN_BITS;
      3'd2:    cbCount = colCount >> (ALIGN_BITS - 1);
      default: cbCount = colCount >> (ALIGN_BITS - 2);
    endcase
  end

  assign lastR     = (rIdx == RIDX_W'(FRAC_ROWS - 1));
  assign lastRb    = (rbIdx == rbLastQ);
  assign lastCb    = (cbIdx == cbLastQ);
  assign lastBeat  = lastR && lastRb && lastCb;
  assign strideX15 = (strideQ << RIDX_W) - strideQ;
  assign srcAddr   = rowPtr + colOff;
  assign dstAddr   = dstPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowPtr <= '0; colOff <= '0; dstPtr <= '0; strideQ <= '0; srcBaseQ <= '0;
      rIdx <= '0; rbIdx <= '0; cbIdx <= '0; rbLastQ <= '0; cbLastQ <= '0; znQ <= 1'b0;
    end else if (strobe.load) begin
      rowPtr   <= srcBase;
      srcBaseQ <= srcBase;
      colOff   <= '0;
      dstPtr   <= dstBase;
      strideQ  <= rowStride;
      rIdx     <= '0;
      rbIdx    <= '0;
      cbIdx    <= '0;
      rbLastQ  <= (rowCount >> RIDX_W) - DIM_W'(1);
      cbLastQ  <= cbCount - DIM_W'(1);
      znQ      <= modeZn;
    end else if (strobe.adv) begin
      dstPtr <= dstPtr + STEP;
      rIdx   <= rIdx + RIDX_W'(1);
      if (!znQ) begin
        // bands fastest, column blocks slowest
        if (lastR && lastRb) begin
          rowPtr <= srcBaseQ;
          colOff <= colOff + STEP;
        end else begin
          rowPtr <= rowPtr + strideQ;
        end
        if (lastR) begin
          if (lastRb) begin
            rbIdx <= '0;
            cbIdx <= cbIdx + DIM_W'(1);
          end else begin
            rbIdx <= rbIdx + DIM_W'(1);
          end
        end
      end else begin
        // column blocks fastest within a band
        if (lastR && !lastCb) begin
          rowPtr <= rowPtr - strideX15;
          colOff <= colOff + STEP;
        end else if (lastR) begin
          rowPtr <= rowPtr + strideQ;
          colOff <= '0;
        end else begin
          rowPtr <= rowPtr + strideQ;
        end
        if (lastR) begin
          if (lastCb) begin
            cbIdx <= '0;
            rbIdx <= rbIdx + DIM_W'(1);
          end else begin
            cbIdx <= cbIdx + DIM_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ndnz_tile_loader.sv
module ndnz_tile_loader
  import ndnz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  localparam int DATA_W = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeZn,
  input  logic [2:0]        elemSize,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] rowStride,
  input  logic [DIM_W-1:0]  rowCount,
  input  logic [DIM_W-1:0]  colCount,
  output logic              beatValid,
  input  logic              beatReady,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              errFlag
);
  ctl_strobe_t strobe;
  logic        lastBeat;

  ndnz_ctrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .srcBase(srcBase), .dstBase(dstBase), .rowStride(rowStride),
    .rowCount(rowCount), .colCount(colCount), .elemSize(elemSize),
    .beatReady(beatReady), .lastBeat(lastBeat),
    .strobe(strobe), .busy(busy), .done(done), .errFlag(errFlag)
  );

  ndnz_addr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_addr (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeZn(modeZn), .elemSize(elemSize),
    .srcBase(srcBase), .dstBase(dstBase), .rowStride(rowStride),
    .rowCount(rowCount), .colCount(colCount),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .lastBeat(lastBeat)
  );

  assign beatValid = busy;
  assign wrData    = rdData;
endmodule

// File: rtl/ndnz_checker.sv
module ndnz_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              beatValid,
  input logic              beatReady,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input logic              busy,
  input logic              done,
  input logic              errFlag
);
  // R9: a stalled beat keeps its position
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=> beatValid && $stable(srcAddr) && $stable(dstAddr));

  // R5: destination advances by one beat per acceptance
  p_dst_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady |=> !beatValid || (dstAddr == $past(dstAddr) + ADDR_W'(32)));

  // R10: done follows an accepted beat and the block is idle
  p_done_timing_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(beatValid && beatReady));

  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && errFlag));

  // R2 (also R3, R4): a refusal follows an idle start and issues nothing
  p_err_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(start) && !$past(busy) && !busy);

  // R11: a start during a stalled transfer does not disturb it
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !beatReady |=> busy && $stable(dstAddr));
endmodule

bind ndnz_tile_loader ndnz_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .beatValid(beatValid), .beatReady(beatReady),
  .srcAddr(srcAddr), .dstAddr(dstAddr), .busy(busy), .done(done), .errFlag(errFlag)
);

// File: tb/ndnz_tile_loader_test.sv
module ndnz_tile_loader_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, modeZn = 1'b0, beatReady = 1'b0;
  logic [2:0] elemSize = 3'd2;
  logic [31:0] srcBase = '0, dstBase = '0, rowStride = '0;
  logic [15:0] rowCount = '0, colCount = '0;
  logic [255:0] rdData = '0;
  logic beatValid, busy, done, errFlag;
  logic [31:0] srcAddr, dstAddr;
  logic [255:0] wrData;

  ndnz_tile_loader uut (
    .clk(clk), .rstN(rstN), .start(start), .modeZn(modeZn), .elemSize(elemSize),
    .srcBase(srcBase), .dstBase(dstBase), .rowStride(rowStride),
    .rowCount(rowCount), .colCount(colCount), .beatValid(beatValid), .beatReady(beatReady),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .rdData(rdData), .wrData(wrData),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, readyMode = 0;
  bit expectDone = 0, doneSeen = 0;
  string orderTag = "R6";
  logic [63:0] expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor and ready driver
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (expectDone) begin
        check(done && !busy, "R10", "done/busy after last beat", {done, busy}, 2'b10);
        expectDone = 0;
        doneSeen = 1;
      end else if (done) begin
        check(0, "R10", "unexpected done", done, 0);
      end
      case (readyMode)
        0: beatReady = 1'b1;
        1: beatReady = cyc[0];
        default: beatReady = (cyc % 3) != 0;
      endcase
      rdData = {8{cyc[31:0]}};
      #1;
      if (beatValid && beatReady) begin
        if (expQ.size() == 0) begin
          check(0, "R11", "beat with nothing expected", {srcAddr, dstAddr}, 0);
        end else begin
          logic [63:0] e;
          e = expQ.pop_front();
          check(srcAddr == e[63:32], orderTag, "source address", srcAddr, e[63:32]);
          check(dstAddr == e[31:0], "R5", "destination address", dstAddr, e[31:0]);
          check(wrData == rdData, "R12", "data pass-through", wrData[63:0], rdData[63:0]);
          if (expQ.size() == 0) expectDone = 1;
        end
      end
    end
  end

  task automatic setDesc(input bit zn, input int es, input int sb, input int db,
                         input int st, input int rows, input int cols);
    modeZn = zn; elemSize = 3'(es); srcBase = sb; dstBase = db;
    rowStride = st; rowCount = 16'(rows); colCount = 16'(cols);
  endtask

  // pushes the expected address pairs, then starts the block (R6, R7, R8)
  task automatic runXfer(input bit zn, input int es, input int sb, input int db,
                         input int st, input int rows, input int cols, input bit midStart);
    int nRb, nCb, n;
    nRb = rows / 16;
    nCb = (cols * es) / 32;
    n = 0;
    orderTag = zn ? "R7" : "R6";
    if (!zn) begin
      for (int cb = 0; cb < nCb; cb++)
        for (int rb = 0; rb < nRb; rb++)
          for (int r = 0; r < 16; r++) begin
            expQ.push_back({32'(sb + (rb*16 + r)*st + cb*32), 32'(db + n*32)});
            n++;
          end
    end else begin
      for (int rb = 0; rb < nRb; rb++)
        for (int cb = 0; cb < nCb; cb++)
          for (int r = 0; r < 16; r++) begin
            expQ.push_back({32'(sb + (rb*16 + r)*st + cb*32), 32'(db + n*32)});
            n++;
          end
    end
    check(n == nRb * nCb * 16, "R8", "beat count of transfer", n, nRb * nCb * 16);
    doneSeen = 0;
    @(negedge clk);
    setDesc(zn, es, sb, db, st, rows, cols);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (5) @(negedge clk);
      // R11: a different descriptor while busy must be ignored
      setDesc(!zn, 1, 32'h9000, 32'hA000, 64, 16, 32);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R11", "still busy after ignored start", busy, 1);
    end
    for (int t = 0; t < 5000 && !doneSeen; t++) @(negedge clk);
    check(doneSeen && expQ.size() == 0, "R8", "transfer completed", expQ.size(), 0);
    repeat (4) @(negedge clk);
    check(!busy && !beatValid, "R11", "no second transfer", {busy, beatValid}, 0);
  endtask

  // a refused descriptor: one-cycle error, no beats (R2, R3, R4)
  task automatic badDesc(input string req, input int es, input int sb, input int db,
                         input int st, input int rows, input int cols);
    @(negedge clk);
    setDesc(0, es, sb, db, st, rows, cols);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(errFlag && !busy, req, "error pulse", {errFlag, busy}, 2'b10);
    @(negedge clk);
    check(!errFlag, req, "error pulse width", errFlag, 0);
    repeat (3) @(negedge clk);
    check(!beatValid && !busy, req, "no beats after refusal", {beatValid, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!beatValid && !busy && !done && !errFlag, "R1", "reset outputs",
          {beatValid, busy, done, errFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!beatValid && !busy, "R1", "idle after reset", {beatValid, busy}, 0);

    readyMode = 0;
    runXfer(0, 2, 32'h1000, 32'h8000, 128, 32, 32, 0);
    readyMode = 1;
    runXfer(0, 1, 32'h2000, 32'h9000, 64, 16, 64, 0);
    readyMode = 2;
    runXfer(1, 4, 32'h3000, 32'hA000, 96, 32, 16, 0);
    readyMode = 1;
    runXfer(0, 2, 32'h4000, 32'hB000, 64, 16, 32, 1);
    readyMode = 0;

    badDesc("R2", 2, 32'h1004, 32'h8000, 64, 16, 16);
    badDesc("R2", 2, 32'h1000, 32'h8010, 64, 16, 16);
    badDesc("R2", 2, 32'h1000, 32'h8000, 72, 16, 16);
    badDesc("R3", 3, 32'h1000, 32'h8000, 64, 16, 16);
    badDesc("R4", 2, 32'h1000, 32'h8000, 64, 24, 16);
    badDesc("R4", 2, 32'h1000, 32'h8000, 64, 16, 8);
    badDesc("R4", 1, 32'h1000, 32'h8000, 64, 16, 0);

    // R9 is also covered by the stalled runs above; one more after refusals
    readyMode = 2;
    runXfer(1, 2, 32'h5000, 32'hC000, 32, 16, 16, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R10", "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule